// File: doc/BRIEF.md
# Burst-Two Shared-Bus SRAM Engine

This block is a cycle-level synchronous model of a static RAM that moves data at double rate over one shared data bus, in fixed bursts of two words. Every clock cycle the host can present one command: an address together with a read request or a write request. Each clock cycle carries two data beats. The rising-edge beat and the inverted-clock beat are shown as two parallel lanes, `rise` and `fall`, so the whole model runs on a single clock.

Writes are late. The two data beats and their per-byte enables follow the write command by one cycle. They wait in a one-entry write buffer and are committed to the array one cycle after that. A read returns its two-word burst two cycles after the command, together with a valid strobe. A read that hits a write still held in the buffer gets the buffered bytes merged over the array contents, so reads always see the most recent write.

Top module: `bt_sram_engine`

## Requirements
- R1: The block samples a command only at the rising clock edge and accepts one per cycle. If `cmd_rd` and `cmd_wr` are both high, the write is performed and the read is dropped, so no `rvalid` results from it.
- R2: A burst covers two words. The rise beat uses `cmd_addr` and the fall beat uses `cmd_addr` with bit 0 inverted. An odd start address therefore writes its rise beat to the odd word and its fall beat to the even word below it.
- R3: For a write, `wdata_rise` and `wbe_rise` are taken at the rising edge one cycle after the edge that sampled the command.
- R4: The second write beat, `wdata_fall` with `wbe_fall`, is taken at that same edge as the second word of the burst.
- R5: Byte enables are active-high. Bit i of an enable covers data bits [9i+8:9i]. A byte whose enable is low keeps its previous contents.
- R6: For a read sampled at edge k, `rdata_rise` holds the word at the command address after edge k+2.
- R7: In that same cycle `rdata_fall` holds the word at the address with bit 0 inverted.
- R8: `rvalid` is high exactly in the cycles that carry read data. In every other cycle `rvalid`, `rdata_rise` and `rdata_fall` are zero.
- R9: A read issued one cycle after a write to the same word pair, while that write's data is still buffered, returns the new bytes where enables were set and the older array bytes elsewhere.
- R10: Synchronous active-high `rst` clears the read and write pipelines and `rvalid` at the next edge. The array contents survive reset.
- R11: Reads on consecutive cycles give `rvalid` on consecutive cycles, each carrying its own burst, in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr | input | ADDR_W | Word address of the burst's first beat |
| cmd_rd | input | 1 | Read request |
| cmd_wr | input | 1 | Write request (wins over read) |
| wdata_rise | input | NB*9 | First write beat, one cycle after the write command |
| wdata_fall | input | NB*9 | Second write beat, same cycle as the first |
| wbe_rise | input | NB | Byte enables of the first write beat |
| wbe_fall | input | NB | Byte enables of the second write beat |
| rdata_rise | output | NB*9 | First read beat |
| rdata_fall | output | NB*9 | Second read beat |
| rvalid | output | 1 | High while read beats are on the outputs |

## Verification
A read cycle can overlap the data cycle of the previous write. The read's array lookup then lands on the same edge on which the buffered write commits, so forwarding and commit coincide. The bench provokes this by issuing a read to the pair one cycle after its write command, using partial byte enables on both beats. It judges the returned burst byte by byte against a reference image updated with the same enables. A second collision, read and write requested in one cycle, is judged by checking that `rvalid` stays low two cycles later and that a subsequent read returns the written data.

// File: rtl/bt_sram_pkg.sv
package bt_sram_pkg;
  localparam int unsigned LANE_W = 9;
endpackage

// File: rtl/bt_sram_wr_pipe.sv
module bt_sram_wr_pipe
  import bt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_acc,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [NB*LANE_W-1:0]   wd_rise,
  input  logic [NB*LANE_W-1:0]   wd_fall,
  input  logic [NB-1:0]          be_rise,
  input  logic [NB-1:0]          be_fall,
  output logic                   buf_vld,
  output logic [ADDR_W-2:0]      buf_pair,
  output logic [2*NB*LANE_W-1:0] buf_data,
  output logic [2*NB-1:0]        buf_be
);
  logic              wc_vld;
  logic [ADDR_W-1:0] wc_addr;

  // stage A: command edge; stage B: data edge (buffer entry)
  always_ff @(posedge clk) begin
    if (rst) begin
      wc_vld  <= 1'b0;
      buf_vld <= 1'b0;
    end else begin
      wc_vld  <= wr_acc;
      buf_vld <= wc_vld;
    end
    wc_addr  <= cmd_addr;
    buf_pair <= wc_addr[ADDR_W-1:1];
    if (wc_addr[0]) begin
      buf_data <= {wd_rise, wd_fall};
      buf_be   <= {be_rise, be_fall};
    end else begin
      buf_data <= {wd_fall, wd_rise};
      buf_be   <= {be_fall, be_rise};
    end
  end

  // buffer entry must stem from a write accepted two edges earlier
  assert_buf_origin_R3: assert property (@(posedge clk) disable iff (rst)
    buf_vld |-> $past(wr_acc, 2));
endmodule

// File: rtl/bt_sram_array.sv
module bt_sram_array
  import bt_sram_pkg::*;
#(
  parameter int unsigned PAIR_AW = 5,
  parameter int unsigned NB      = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [PAIR_AW-1:0]     waddr,
  input  logic [2*NB*LANE_W-1:0] wdata,
  input  logic [2*NB-1:0]        wbe,
  input  logic [PAIR_AW-1:0]     raddr,
  output logic [2*NB*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << PAIR_AW;
  localparam int unsigned LANES = 2 * NB;

  logic [2*NB*LANE_W-1:0] mem [DEPTH];

  // one byte-enabled write port, one registered read-first port
  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wbe[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bt_sram_rd_pipe.sv
module bt_sram_rd_pipe
  import bt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_acc,
  input  logic [ADDR_W-1:0]      cmd_addr,
  output logic [ADDR_W-2:0]      ram_raddr,
  input  logic [2*NB*LANE_W-1:0] ram_q,
  input  logic                   buf_vld,
  input  logic [ADDR_W-2:0]      buf_pair,
  input  logic [2*NB*LANE_W-1:0] buf_data,
  input  logic [2*NB-1:0]        buf_be,
  output logic [NB*LANE_W-1:0]   rdata_rise,
  output logic [NB*LANE_W-1:0]   rdata_fall,
  output logic                   rvalid
);
  localparam int unsigned DW    = NB * LANE_W;
  localparam int unsigned LANES = 2 * NB;

  logic              s1_vld, s2_vld, s2_lsb;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  fwd_be;
  logic [2*DW-1:0]   fwd_data, merged;

  assign ram_raddr = s1_addr[ADDR_W-1:1];

  // per-lane overlay of the uncommitted write on the array word pair
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = fwd_be[g] ? fwd_data[g*LANE_W +: LANE_W]
                                                  : ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      s2_vld     <= 1'b0;
      rvalid     <= 1'b0;
      rdata_rise <= '0;
      rdata_fall <= '0;
      fwd_be     <= '0;
    end else begin
      s1_vld <= rd_acc;
      s2_vld <= s1_vld;
      rvalid <= s2_vld;
      fwd_be <= (buf_vld && buf_pair == s1_addr[ADDR_W-1:1]) ? buf_be : '0;
      if (s2_vld) begin
        rdata_rise <= s2_lsb ? merged[2*DW-1:DW] : merged[DW-1:0];
        rdata_fall <= s2_lsb ? merged[DW-1:0]    : merged[2*DW-1:DW];
      end else begin
        rdata_rise <= '0;
        rdata_fall <= '0;
      end
    end
    s1_addr  <= cmd_addr;
    s2_lsb   <= s1_addr[0];
    fwd_data <= buf_data;
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata_rise == '0 && rdata_fall == '0));
  assert_rvalid_src_R8: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_acc, 3));
endmodule

// File: rtl/bt_sram_engine.sv
module bt_sram_engine
  import bt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic                  cmd_rd,
  input  logic                  cmd_wr,
  input  logic [NB*LANE_W-1:0]  wdata_rise,
  input  logic [NB*LANE_W-1:0]  wdata_fall,
  input  logic [NB-1:0]         wbe_rise,
  input  logic [NB-1:0]         wbe_fall,
  output logic [NB*LANE_W-1:0]  rdata_rise,
  output logic [NB*LANE_W-1:0]  rdata_fall,
  output logic                  rvalid
);
  localparam int unsigned DW      = NB * LANE_W;
  localparam int unsigned PAIR_AW = ADDR_W - 1;

  logic               wr_acc, rd_acc, buf_vld;
  logic [PAIR_AW-1:0] buf_pair, ram_raddr;
  logic [2*DW-1:0]    buf_data, ram_q;
  logic [2*NB-1:0]    buf_be;

  // write has priority over a read in the same cycle
  assign wr_acc = cmd_wr;
  assign rd_acc = cmd_rd && !cmd_wr;

  bt_sram_wr_pipe #(.ADDR_W(ADDR_W), .NB(NB)) u_wr (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .cmd_addr(cmd_addr),
    .wd_rise(wdata_rise), .wd_fall(wdata_fall),
    .be_rise(wbe_rise), .be_fall(wbe_fall),
    .buf_vld(buf_vld), .buf_pair(buf_pair), .buf_data(buf_data), .buf_be(buf_be)
  );

  bt_sram_array #(.PAIR_AW(PAIR_AW), .NB(NB)) u_mem (
    .clk(clk), .we(buf_vld), .waddr(buf_pair), .wdata(buf_data), .wbe(buf_be),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  bt_sram_rd_pipe #(.ADDR_W(ADDR_W), .NB(NB)) u_rd (
    .clk(clk), .rst(rst), .rd_acc(rd_acc), .cmd_addr(cmd_addr),
    .ram_raddr(ram_raddr), .ram_q(ram_q),
    .buf_vld(buf_vld), .buf_pair(buf_pair), .buf_data(buf_data), .buf_be(buf_be),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall), .rvalid(rvalid)
  );

  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && !cmd_wr) |-> ##3 rvalid);
  assert_wr_wins_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> ##3 !rvalid);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !rvalid);
endmodule

// File: tb/bt_sram_engine_tb_top.sv
module bt_sram_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cmd_addr = '0;
  logic        cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [17:0] wdata_rise = '0, wdata_fall = '0;
  logic [1:0]  wbe_rise = '0, wbe_fall = '0;
  logic [17:0] rdata_rise, rdata_fall;
  logic        rvalid;

  int checks = 0;
  int fails  = 0;
  logic [17:0] ref_mem [64];

  always #10 clk = ~clk;

  bt_sram_engine dut_i (
    .clk(clk), .rst(rst), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall), .rvalid(rvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d,
                                        input logic [1:0] be);
    merge = old;
    if (be[0]) merge[8:0]  = d[8:0];
    if (be[1]) merge[17:9] = d[17:9];
  endfunction

  // drive one cycle of inputs, then move to the next falling edge
  task automatic drive(input logic rd, input logic wr, input logic [5:0] a,
                       input logic [17:0] dr, input logic [17:0] df,
                       input logic [1:0] br, input logic [1:0] bf);
    cmd_rd = rd; cmd_wr = wr; cmd_addr = a;
    wdata_rise = dr; wdata_fall = df; wbe_rise = br; wbe_fall = bf;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 6'd0, '0, '0, '0, '0);
  endtask

  task automatic model_wr(input logic [5:0] a, input logic [17:0] d0, input logic [17:0] d1,
                          input logic [1:0] b0, input logic [1:0] b1);
    ref_mem[a]        = merge(ref_mem[a], d0, b0);
    ref_mem[a ^ 6'd1] = merge(ref_mem[a ^ 6'd1], d1, b1);
  endtask

  task automatic wr_burst(input logic [5:0] a, input logic [17:0] d0, input logic [17:0] d1,
                          input logic [1:0] b0, input logic [1:0] b1);
    drive(1'b0, 1'b1, a, '0, '0, '0, '0);
    drive(1'b0, 1'b0, 6'd0, d0, d1, b0, b1);
    model_wr(a, d0, d1, b0, b1);
  endtask

  task automatic rd_check(input logic [5:0] a, input string req);
    drive(1'b1, 1'b0, a, '0, '0, '0, '0);
    idle(); idle();
    chk({req, " rvalid"}, 32'(rvalid), 32'd1);
    chk({req, " rise"}, 32'(rdata_rise), 32'(ref_mem[a]));
    chk({req, " fall"}, 32'(rdata_fall), 32'(ref_mem[a ^ 6'd1]));
  endtask

  task automatic t_reset();
    chk("R10 rvalid in reset", 32'(rvalid), 32'd0);
    chk("R8 rise idle", 32'(rdata_rise), 32'd0);
    chk("R8 fall idle", 32'(rdata_fall), 32'd0);
  endtask

  task automatic t_basic();
    wr_burst(6'd4, 18'h1A5A5, 18'h0C3C3, 2'b11, 2'b11);
    idle();
    rd_check(6'd4, "R3 R4 R6 R7 even");
    idle();
    chk("R8 idle after read", 32'(rvalid), 32'd0);
    chk("R8 idle data", 32'(rdata_rise), 32'd0);
  endtask

  task automatic t_odd();
    wr_burst(6'd11, 18'h2AAAA, 18'h15555, 2'b11, 2'b11);
    idle();
    rd_check(6'd10, "R2 even of pair");
    chk("R2 fall beat to even word", 32'(rdata_rise), 32'h15555);
    rd_check(6'd11, "R2 odd start");
  endtask

  task automatic t_bytes();
    wr_burst(6'd20, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11);
    wr_burst(6'd20, 18'h00000, 18'h00000, 2'b01, 2'b10);
    idle();
    rd_check(6'd20, "R5 partial");
    chk("R5 lane value", 32'(rdata_rise), 32'h3FE00);
  endtask

  task automatic t_b2b();
    wr_burst(6'd30, 18'h00111, 18'h00222, 2'b11, 2'b11);
    wr_burst(6'd40, 18'h00333, 18'h00444, 2'b11, 2'b11);
    idle();
    drive(1'b1, 1'b0, 6'd30, '0, '0, '0, '0);
    drive(1'b1, 1'b0, 6'd41, '0, '0, '0, '0);
    idle();
    chk("R11 first rvalid", 32'(rvalid), 32'd1);
    chk("R11 first rise", 32'(rdata_rise), 32'h00111);
    idle();
    chk("R11 second rvalid", 32'(rvalid), 32'd1);
    chk("R11 second rise", 32'(rdata_rise), 32'h00444);
    chk("R11 second fall", 32'(rdata_fall), 32'h00333);
    idle();
    chk("R8 drop after burst", 32'(rvalid), 32'd0);
  endtask

  task automatic t_coherent();
    wr_burst(6'd50, 18'h11111, 18'h22222, 2'b11, 2'b11);
    idle();
    drive(1'b0, 1'b1, 6'd50, '0, '0, '0, '0);
    drive(1'b1, 1'b0, 6'd50, 18'h3ABCD, 18'h01234, 2'b10, 2'b01);
    model_wr(6'd50, 18'h3ABCD, 18'h01234, 2'b10, 2'b01);
    idle(); idle();
    chk("R9 rvalid", 32'(rvalid), 32'd1);
    chk("R9 merged rise", 32'(rdata_rise), 32'(ref_mem[50]));
    chk("R9 merged fall", 32'(rdata_fall), 32'(ref_mem[51]));
    idle();
    rd_check(6'd50, "R9 after commit");
  endtask

  task automatic t_collide();
    drive(1'b1, 1'b1, 6'd60, '0, '0, '0, '0);
    drive(1'b0, 1'b0, 6'd0, 18'h0BEEF, 18'h0CAFE, 2'b11, 2'b11);
    model_wr(6'd60, 18'h0BEEF, 18'h0CAFE, 2'b11, 2'b11);
    idle();
    chk("R1 read dropped", 32'(rvalid), 32'd0);
    rd_check(6'd60, "R1 write taken");
  endtask

  task automatic t_midreset();
    drive(1'b1, 1'b0, 6'd4, '0, '0, '0, '0);
    rst = 1'b1;
    idle(); idle();
    chk("R10 pending read cleared", 32'(rvalid), 32'd0);
    rst = 1'b0;
    idle();
    chk("R10 stays clear", 32'(rvalid), 32'd0);
    rd_check(6'd4, "R10 array kept");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    // give every word a known value before any read
    for (int a = 0; a < 64; a += 2) wr_burst(6'(a), '0, '0, 2'b11, 2'b11);
    idle();
    t_basic();
    t_odd();
    t_bytes();
    t_b2b();
    t_coherent();
    t_collide();
    t_midreset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule